// File: doc/BRIEF.md
# Fully Associative Page Translation Cache

This block keeps a small set of recent virtual-to-physical page translations and answers lookups in the same cycle they are presented. A lookup supplies a 43-bit virtual address, an access kind (load or store) and a privilege mode (kernel or user). The upper 30 bits of the address are compared against the tag of every valid slot at once. On a match, the block returns a 34-bit physical address and checks the slot's permission bits against the access. Without a match, it reports a miss so that an outside walker can fetch the translation.

Translations are installed only through an explicit fill port. The fill target is either a slot index given by the caller or the current pseudo-random victim index, which the block also outputs. A single invalidate strobe empties the whole cache. The block does no table walking of its own and has no address-space tagging. It supports one page size of 8 KiB.

Top module: `page_xlat_buf`

## Requirements
- R1: When `lk_valid` is 1 and a valid slot holds a tag equal to `lk_vaddr[42:13]`, `lk_hit` is 1 and `lk_miss` is 0 in that same cycle.
- R2: When `lk_valid` is 1 and no valid slot matches, `lk_miss` is 1 and `lk_hit` is 0. When `lk_valid` is 0, both are 0.
- R3: On a hit, `lk_paddr` equals the slot's 21-bit frame number placed above `lk_vaddr[12:0]`, with the offset passed through unchanged. Without a hit, `lk_paddr` is all zeros.
- R4: Each slot has a 2-bit read-enable field and a 2-bit write-enable field. In both fields, bit 0 grants kernel mode (`lk_user`=0) and bit 1 grants user mode (`lk_user`=1). `lk_fault` is 1 exactly when there is a hit and the bit chosen by `lk_write` (0 selects the read field, 1 selects the write field) and by the mode is 0.
- R5: A fill with `fill_en`=1 takes effect at the next rising clock edge. A lookup in the same cycle as the fill still sees the earlier contents.
- R6: The fill writes slot `victim_idx` when `fill_use_victim` is 1, and slot `fill_idx` otherwise. The fill replaces any translation held in that slot.
- R7: `inval_all` clears every slot at the next edge. If a fill arrives in the same cycle, the invalidate wins and the fill is dropped.
- R8: `victim_idx` comes from a 5-bit LFSR. It reads 1 in reset and then advances on every clock edge as next = {v[3:0], v[4]^v[2]}. It never reads 0 and repeats every 31 cycles.
- R9: After reset, no slot is valid, so every lookup misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| lk_valid | input | 1 | Lookup request present |
| lk_vaddr | input | 43 | Virtual address to translate |
| lk_write | input | 1 | 1 for a store, 0 for a load |
| lk_user | input | 1 | 1 for user mode, 0 for kernel mode |
| lk_hit | output | 1 | Translation found |
| lk_miss | output | 1 | Request present but no translation held |
| lk_fault | output | 1 | Hit whose permission bit denies the access |
| lk_paddr | output | 34 | Translated physical address |
| fill_en | input | 1 | Install a translation |
| fill_use_victim | input | 1 | Target the random victim slot instead of `fill_idx` |
| fill_idx | input | 5 | Explicit target slot |
| fill_vpn | input | 30 | Virtual page number to install |
| fill_ppn | input | 21 | Physical frame number to install |
| fill_rd | input | 2 | Read enables {user, kernel} |
| fill_wr | input | 2 | Write enables {user, kernel} |
| inval_all | input | 1 | Clear every slot |
| victim_idx | output | 5 | Current replacement candidate |

## Verification
The bench builds the block with its default values: 32 slots, a 43-bit virtual address, 13 offset bits and a 21-bit frame number. With these values every slot can be filled by explicit index, so a full table can be probed in all four mode and access combinations. The 31-step victim sequence is short enough to be followed through a complete period. Random-victim fills are tracked through the observed `victim_idx`, which lets the bench predict which older translation an eviction removes.

// File: rtl/pxb_pkg.sv
package pxb_pkg;

  // Permission bits of one slot: index 0 = kernel, index 1 = user.
  typedef struct packed {
    logic [1:0] rd;
    logic [1:0] wr;
  } perm_t;

  function automatic logic perm_allows(input perm_t p, input logic is_write,
                                       input logic is_user);
    logic [1:0] fld;
    fld = is_write ? p.wr : p.rd;
    return fld[is_user];
  endfunction

  // Maximal-length feedback taps for a shift-left Fibonacci LFSR.
  function automatic logic [15:0] lfsr_taps(input int w);
    case (w)
      2:       return 16'h0003;
      3:       return 16'h0006;
      4:       return 16'h000C;
      5:       return 16'h0014;
      6:       return 16'h0030;
      7:       return 16'h0060;
      8:       return 16'h00B8;
      default: return 16'h0014;
    endcase
  endfunction

endpackage

// File: rtl/xlat_victim_lfsr.sv
module xlat_victim_lfsr #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  output logic [W-1:0] state
);
  localparam logic [15:0]  TAPS_ALL = pxb_pkg::lfsr_taps(W);
  localparam logic [W-1:0] TAPS     = TAPS_ALL[W-1:0];

  logic [W-1:0] st_q, st_d;
  logic         adv_en;

  assign adv_en = 1'b1;

  always_comb begin
    st_d = st_q;
    if (adv_en) st_d = {st_q[W-2:0], ^(st_q & TAPS)};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= W'(1);
    else        st_q <= st_d;
  end

  assign state = st_q;
endmodule

// File: rtl/xlat_entry_array.sv
module xlat_entry_array #(
  parameter int N     = 32,
  parameter int TAG_W = 30,
  parameter int PPN_W = 21,
  localparam int IDX_W = $clog2(N)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [TAG_W-1:0]     lk_tag,
  input  logic                 wr_en,
  input  logic [IDX_W-1:0]     wr_idx,
  input  logic [TAG_W-1:0]     wr_tag,
  input  logic [PPN_W-1:0]     wr_ppn,
  input  pxb_pkg::perm_t       wr_perm,
  input  logic                 clr_all,
  output logic                 match_any,
  output logic [PPN_W-1:0]     sel_ppn,
  output pxb_pkg::perm_t       sel_perm
);
  logic [N-1:0]     valid_q, valid_d;
  logic [N-1:0]     slot_we;
  logic [N-1:0]     hit_vec;
  logic [TAG_W-1:0] tag_q  [N];
  logic [PPN_W-1:0] ppn_q  [N];
  pxb_pkg::perm_t   perm_q [N];

  for (genvar e = 0; e < N; e++) begin : g_slot
    assign slot_we[e] = wr_en && !clr_all && (wr_idx == IDX_W'(e));
    assign hit_vec[e] = valid_q[e] && (tag_q[e] == lk_tag);
  end

  always_comb begin
    valid_d = valid_q | slot_we;
    if (clr_all) valid_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= '0;
    else        valid_q <= valid_d;
  end

  always_ff @(posedge clk) begin
    for (int e = 0; e < N; e++) begin
      if (slot_we[e]) begin
        tag_q[e]  <= wr_tag;
        ppn_q[e]  <= wr_ppn;
        perm_q[e] <= wr_perm;
      end
    end
  end

  // One-hot AND-OR selection of the matching slot.
  always_comb begin
    sel_ppn  = '0;
    sel_perm = '0;
    for (int e = 0; e < N; e++) begin
      sel_ppn  = sel_ppn | ({PPN_W{hit_vec[e]}} & ppn_q[e]);
      sel_perm = pxb_pkg::perm_t'(sel_perm | ({4{hit_vec[e]}} & perm_q[e]));
    end
  end

  assign match_any = |hit_vec;
endmodule

// File: rtl/xlat_perm_check.sv
module xlat_perm_check (
  input  logic           hit,
  input  pxb_pkg::perm_t perm,
  input  logic           is_write,
  input  logic           is_user,
  output logic           fault
);
  assign fault = hit && !pxb_pkg::perm_allows(perm, is_write, is_user);
endmodule

// File: rtl/page_xlat_buf.sv
module page_xlat_buf #(
  parameter int N     = 32,
  parameter int VA_W  = 43,
  parameter int OFF_W = 13,
  parameter int PPN_W = 21,
  localparam int VPN_W = VA_W - OFF_W,
  localparam int PA_W  = PPN_W + OFF_W,
  localparam int IDX_W = $clog2(N)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lk_valid,
  input  logic [VA_W-1:0]  lk_vaddr,
  input  logic             lk_write,
  input  logic             lk_user,
  output logic             lk_hit,
  output logic             lk_miss,
  output logic             lk_fault,
  output logic [PA_W-1:0]  lk_paddr,
  input  logic             fill_en,
  input  logic             fill_use_victim,
  input  logic [IDX_W-1:0] fill_idx,
  input  logic [VPN_W-1:0] fill_vpn,
  input  logic [PPN_W-1:0] fill_ppn,
  input  logic [1:0]       fill_rd,
  input  logic [1:0]       fill_wr,
  input  logic             inval_all,
  output logic [IDX_W-1:0] victim_idx
);
  logic rst_meta_q, rst_q_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_q_n    <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_q_n    <= rst_meta_q;
    end
  end

  logic [IDX_W-1:0] tgt_idx;
  logic             match_any;
  logic [PPN_W-1:0] sel_ppn;
  pxb_pkg::perm_t   sel_perm, fill_perm;

  assign tgt_idx   = fill_use_victim ? victim_idx : fill_idx;
  assign fill_perm = '{rd: fill_rd, wr: fill_wr};

  xlat_victim_lfsr #(.W(IDX_W)) u_lfsr (
    .clk   (clk),
    .rst_n (rst_q_n),
    .state (victim_idx)
  );

  xlat_entry_array #(.N(N), .TAG_W(VPN_W), .PPN_W(PPN_W)) u_array (
    .clk       (clk),
    .rst_n     (rst_q_n),
    .lk_tag    (lk_vaddr[VA_W-1:OFF_W]),
    .wr_en     (fill_en),
    .wr_idx    (tgt_idx),
    .wr_tag    (fill_vpn),
    .wr_ppn    (fill_ppn),
    .wr_perm   (fill_perm),
    .clr_all   (inval_all),
    .match_any (match_any),
    .sel_ppn   (sel_ppn),
    .sel_perm  (sel_perm)
  );

  assign lk_hit   = lk_valid && match_any;
  assign lk_miss  = lk_valid && !match_any;
  assign lk_paddr = lk_hit ? {sel_ppn, lk_vaddr[OFF_W-1:0]} : '0;

  xlat_perm_check u_perm (
    .hit      (lk_hit),
    .perm     (sel_perm),
    .is_write (lk_write),
    .is_user  (lk_user),
    .fault    (lk_fault)
  );
endmodule

// File: rtl/page_xlat_buf_chk.sv
module page_xlat_buf_chk #(
  parameter int VA_W  = 43,
  parameter int OFF_W = 13,
  parameter int PA_W  = 34,
  parameter int IDX_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             lk_valid,
  input logic [VA_W-1:0]  lk_vaddr,
  input logic             lk_hit,
  input logic             lk_miss,
  input logic             lk_fault,
  input logic [PA_W-1:0]  lk_paddr,
  input logic             fill_en,
  input logic [VA_W-OFF_W-1:0] fill_vpn,
  input logic             inval_all,
  input logic [IDX_W-1:0] victim_idx
);
  logic armed_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed_q <= 1'b0;
    else        armed_q <= 1'b1;
  end

  // R1
  hit_miss_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(lk_hit && lk_miss));

  // R2
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |-> (!lk_hit && !lk_miss));

  // R3
  offset_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> (lk_paddr[OFF_W-1:0] == lk_vaddr[OFF_W-1:0]));

  // R3
  paddr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_hit |-> (lk_paddr == '0));

  // R4
  fault_needs_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lk_fault |-> lk_hit);

  // R5
  fill_visible_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_en && !inval_all) ##1
    (lk_valid && lk_vaddr[VA_W-1:OFF_W] == $past(fill_vpn)) |-> lk_hit);

  // R7
  inval_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inval_all |=> !lk_hit);

  // R8
  victim_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    victim_idx != '0);

  // R8
  victim_moves_chk: assert property (@(posedge clk) disable iff (!rst_n)
    armed_q |-> (victim_idx != $past(victim_idx)));
endmodule

bind page_xlat_buf page_xlat_buf_chk #(
  .VA_W(VA_W), .OFF_W(OFF_W), .PA_W(PA_W), .IDX_W(IDX_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_q_n),
  .lk_valid   (lk_valid),
  .lk_vaddr   (lk_vaddr),
  .lk_hit     (lk_hit),
  .lk_miss    (lk_miss),
  .lk_fault   (lk_fault),
  .lk_paddr   (lk_paddr),
  .fill_en    (fill_en),
  .fill_vpn   (fill_vpn),
  .inval_all  (inval_all),
  .victim_idx (victim_idx)
);

// File: tb/test_page_xlat_buf.sv
module test_page_xlat_buf;
  localparam int N = 32, VA_W = 43, OFF_W = 13, PPN_W = 21;
  localparam int VPN_W = VA_W - OFF_W, PA_W = PPN_W + OFF_W, IW = 5;

  logic clk = 1'b0;
  logic rst_n;
  logic lk_valid, lk_write, lk_user;
  logic [VA_W-1:0] lk_vaddr;
  logic lk_hit, lk_miss, lk_fault;
  logic [PA_W-1:0] lk_paddr;
  logic fill_en, fill_use_victim;
  logic [IW-1:0] fill_idx, victim_idx;
  logic [VPN_W-1:0] fill_vpn;
  logic [PPN_W-1:0] fill_ppn;
  logic [1:0] fill_rd, fill_wr;
  logic inval_all;

  page_xlat_buf i_page_xlat_buf (
    .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_vaddr(lk_vaddr),
    .lk_write(lk_write), .lk_user(lk_user), .lk_hit(lk_hit), .lk_miss(lk_miss),
    .lk_fault(lk_fault), .lk_paddr(lk_paddr), .fill_en(fill_en),
    .fill_use_victim(fill_use_victim), .fill_idx(fill_idx), .fill_vpn(fill_vpn),
    .fill_ppn(fill_ppn), .fill_rd(fill_rd), .fill_wr(fill_wr),
    .inval_all(inval_all), .victim_idx(victim_idx)
  );

  always #4 clk = ~clk;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  typedef struct {
    logic hit; logic miss; logic fault; logic [PA_W-1:0] pa; string req;
  } exp_t;
  exp_t exp_q[$];
  event smp_ev;

  // Reference model of the slots
  bit               m_valid [N];
  logic [VPN_W-1:0] m_vpn   [N];
  logic [PPN_W-1:0] m_ppn   [N];
  logic [1:0]       m_rd    [N];
  logic [1:0]       m_wr    [N];

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic exp_t predict(input logic [VA_W-1:0] va, input bit wr,
                                   input bit usr, input bit vld, input string req);
    exp_t e;
    e.hit = 0; e.miss = vld; e.fault = 0; e.pa = '0; e.req = req;
    if (vld) begin
      for (int i = 0; i < N; i++) begin
        if (m_valid[i] && m_vpn[i] == va[VA_W-1:OFF_W]) begin
          e.hit = 1; e.miss = 0;
          e.pa = {m_ppn[i], va[OFF_W-1:0]};
          e.fault = wr ? !m_wr[i][usr] : !m_rd[i][usr];
        end
      end
    end
    return e;
  endfunction

  function automatic logic [IW-1:0] lfsr_next(input logic [IW-1:0] v);
    return {v[3:0], v[4] ^ v[2]};
  endfunction

  // Monitor: pop expected item and compare with the ports
  initial begin
    forever begin
      exp_t e;
      @(smp_ev);
      #2;
      e = exp_q.pop_front();
      chk(e.req, "hit", 64'(lk_hit), 64'(e.hit));
      chk(e.req, "miss", 64'(lk_miss), 64'(e.miss));
      chk(e.req, "fault", 64'(lk_fault), 64'(e.fault));
      chk(e.req, "paddr", 64'(lk_paddr), 64'(e.pa));
    end
  end

  task automatic lookup(input logic [VA_W-1:0] va, input bit wr, input bit usr,
                        input string req);
    @(negedge clk);
    lk_valid = 1; lk_vaddr = va; lk_write = wr; lk_user = usr;
    exp_q.push_back(predict(va, wr, usr, 1, req));
    -> smp_ev;
  endtask

  task automatic idle_look(input logic [VA_W-1:0] va, input string req);
    @(negedge clk);
    lk_valid = 0; lk_vaddr = va; lk_write = 0; lk_user = 0;
    exp_q.push_back(predict(va, 0, 0, 0, req));
    -> smp_ev;
  endtask

  task automatic apply_fill(input bit use_v, input logic [IW-1:0] idx,
                            input logic [VPN_W-1:0] vpn, input logic [PPN_W-1:0] ppn,
                            input logic [1:0] rd, input logic [1:0] wr);
    int t;
    fill_en = 1; fill_use_victim = use_v; fill_idx = idx;
    fill_vpn = vpn; fill_ppn = ppn; fill_rd = rd; fill_wr = wr;
    t = use_v ? int'(victim_idx) : int'(idx);
    if (!inval_all) begin
      m_valid[t] = 1; m_vpn[t] = vpn; m_ppn[t] = ppn; m_rd[t] = rd; m_wr[t] = wr;
    end
  endtask

  task automatic fill(input bit use_v, input logic [IW-1:0] idx,
                      input logic [VPN_W-1:0] vpn, input logic [PPN_W-1:0] ppn,
                      input logic [1:0] rd, input logic [1:0] wr);
    @(negedge clk);
    lk_valid = 0;
    apply_fill(use_v, idx, vpn, ppn, rd, wr);
    @(posedge clk); #1 fill_en = 0;
  endtask

  // Watchdog
  initial begin
    #(8 * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  function automatic logic [VPN_W-1:0] vpn_of(input int e);
    return VPN_W'(30'h2A00_0000 + e * 30'h0001_0123);
  endfunction

  initial begin
    logic [IW-1:0] v, v0;
    for (int i = 0; i < N; i++) m_valid[i] = 0;
    rst_n = 0; lk_valid = 0; lk_vaddr = '0; lk_write = 0; lk_user = 0;
    fill_en = 0; fill_use_victim = 0; fill_idx = '0; fill_vpn = '0;
    fill_ppn = '0; fill_rd = '0; fill_wr = '0; inval_all = 0;
    repeat (3) @(negedge clk);
    // R8 victim reads 1 in reset
    chk("R8", "victim in reset", 64'(victim_idx), 64'd1);
    rst_n = 1;
    repeat (3) @(negedge clk);

    // R9 empty after reset
    lookup({vpn_of(0), 13'h0}, 0, 0, "R9");
    lookup(43'h7FF_FFFF_FFFF, 1, 1, "R9");
    // R2 no request -> neither hit nor miss
    idle_look({vpn_of(0), 13'h5}, "R2");

    // R5/R6 explicit fills of every slot
    for (int e = 0; e < N; e++)
      fill(0, IW'(e), vpn_of(e), PPN_W'(21'h10000 + e * 7), 2'(e), 2'(e >> 2));

    // R1/R3/R4 lookups across modes, kinds, offsets
    for (int e = 0; e < N; e++) begin
      lookup({vpn_of(e), 13'h0000}, 0, 0, "R1");
      lookup({vpn_of(e), 13'h1FFF}, 0, 1, "R3");
      lookup({vpn_of(e), 13'(e * 97)}, 1, 0, "R4");
      lookup({vpn_of(e), 13'h0AAA}, 1, 1, "R4");
    end
    idle_look({vpn_of(3), 13'h1}, "R2");
    // R2 misses on absent pages
    for (int k = 0; k < 5; k++)
      lookup({VPN_W'(30'h0000_0100 + k), 13'h0123}, k[0], k[1], "R2");

    // R5 lookup during a fill sees old contents, then new
    @(negedge clk);
    lk_valid = 1; lk_vaddr = {vpn_of(5), 13'h0042}; lk_write = 0; lk_user = 0;
    exp_q.push_back(predict(lk_vaddr, 0, 0, 1, "R5"));
    apply_fill(0, 5'd5, 30'h1555_5555, 21'h1F0F0, 2'b11, 2'b11);
    -> smp_ev;
    @(posedge clk); #1 fill_en = 0;
    lookup({vpn_of(5), 13'h0042}, 0, 0, "R6");
    lookup({30'h1555_5555, 13'h0042}, 1, 1, "R6");

    // R6 victim fills evict whatever the observed victim slot held
    for (int k = 0; k < 4; k++) begin
      fill(1, 5'd0, VPN_W'(30'h0333_0000 + k), PPN_W'(21'h0AB00 + k), 2'b01, 2'b10);
      lookup({VPN_W'(30'h0333_0000 + k), 13'h0777}, 0, 1, "R6");
    end
    for (int e = 0; e < N; e++)
      lookup({vpn_of(e), 13'h0010}, 0, 0, "R6");

    // R8 victim sequence over a full period
    @(negedge clk);
    lk_valid = 0;
    v0 = victim_idx; v = v0;
    for (int k = 1; k <= 31; k++) begin
      @(negedge clk);
      v = lfsr_next(v);
      chk("R8", "victim step", 64'(victim_idx), 64'(v));
      if (victim_idx == '0) chk("R8", "victim zero", 64'(victim_idx), 64'd1);
    end
    chk("R8", "victim period", 64'(victim_idx), 64'(v0));

    // R7 invalidate wins over a simultaneous fill
    @(negedge clk);
    inval_all = 1;
    apply_fill(0, 5'd9, 30'h0CCC_CCCC, 21'h00077, 2'b11, 2'b11);
    for (int i = 0; i < N; i++) m_valid[i] = 0;
    @(posedge clk); #1 fill_en = 0; inval_all = 0;
    lookup({30'h0CCC_CCCC, 13'h0}, 0, 0, "R7");
    for (int e = 0; e < N; e += 3)
      lookup({vpn_of(e), 13'h0}, 0, 0, "R7");
    lookup({30'h1555_5555, 13'h0}, 0, 0, "R7");

    // R5 refill after invalidate
    fill(0, 5'd31, 30'h3FFF_FFFF, 21'h1FFFF, 2'b10, 2'b00);
    lookup({30'h3FFF_FFFF, 13'h1FFF}, 0, 1, "R5");
    lookup({30'h3FFF_FFFF, 13'h1FFF}, 0, 0, "R4");
    lookup({30'h3FFF_FFFF, 13'h0000}, 1, 1, "R4");

    @(negedge clk);
    lk_valid = 0;
    repeat (2) @(negedge clk);
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule